// File: doc/BRIEF.md
# Operand Address Sequencer

This block works out the operand address for a 16-bit, word-addressed accumulator machine. It receives the first instruction word and, when the instruction is two words long, the second word too. It also receives the address of the word that follows the instruction. The index registers of this machine are not flip-flops. They are ordinary memory words at addresses 1, 2 and 3, so the block owns a read port onto memory and fetches whatever it needs through that port.

A one-cycle `start` pulse hands an instruction to the block while it is idle. The block then issues zero, one or two memory reads:

- one read fetches the selected index word;
- the other reads the pointer word when indirection is requested.

It then raises `done` for one cycle. The 15-bit result on `ea`, and the pass-through field on `modifier`, stay put until the next accepted `start`.

Bit numbering in this brief uses the vector index, so bit 15 is the most significant bit. Within the first word:

| Bits | Field | Meaning |
|---|---|---|
| 10 | format flag | 0 = one-word form, 1 = two-word form |
| 9:8 | index selector | 0 = no index word |
| 7:0 | displacement | signed, one-word form only |
| 7 | indirect flag | two-word form only |
| 6:0 | modifier | passed through to the execution stage |

The address arithmetic works as follows:

- One-word form with selector 0: the displacement is added to the following-word address.
- One-word form with a non-zero selector: the displacement is added to the index word.
- Two-word form: the second word is the base. The index word is added when the selector is non-zero.
- Indirection is applied after indexing.

Top module: `eag_top`

## Requirements
- R1: The format flag is bit 10 of `instr_w0` and the index selector is bits 9:8. In the one-word form (bit 10 = 0), bit 7 is the sign of the displacement and never requests indirection.
- R2: One-word form with selector 0: `ea` = `next_iar` + sign-extended bits 7:0, modulo 2^15. No memory read is issued.
- R3: One-word form with selector k ≠ 0: the block reads memory address k, then `ea` = (read word) + sign-extended displacement, modulo 2^15.
- R4: Two-word form with bit 7 = 0: `ea` = `instr_w1` when the selector is 0. Otherwise `ea` = `instr_w1` + (word at address k). Both are taken modulo 2^15.
- R5: Two-word form with bit 7 = 1: the indexed address from R4 is formed first. That address is then read, and the low 15 bits of the word read become `ea`.
- R6: All sums wrap modulo 2^15. Bit 15 of `instr_w1`, of an index word and of a pointer word is ignored.
- R7: Read timing and the `done` pulse:
  - A read holds `mem_rd_en` high for one cycle with its address. The data is taken on `mem_rd_data` during the following cycle.
  - With n reads (n = 0, 1 or 2), `done` is high exactly in cycle 1+2n, counting the cycle in which `start` is high as cycle 0.
  - `done` lasts one cycle.
- R8: `ea` and `modifier` stay unchanged from `done` until the next accepted `start`, whatever the instruction inputs do meanwhile.
- R9: `start` is ignored while a computation is in progress. The result, its latency and the number of `done` pulses are unaffected.
- R10: `modifier` equals bits 6:0 of the `instr_w0` accepted with `start`.
- R11: While `rst` is high and after it, until the first `start`: `done` = 0, `mem_rd_en` = 0, `ea` = 0 and `modifier` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept the presented instruction (honoured only when idle) |
| instr_w0 | input | 16 | First instruction word |
| instr_w1 | input | 16 | Second instruction word (two-word form only) |
| next_iar | input | 15 | Address of the word after the instruction |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 15 | Memory read address |
| mem_rd_data | input | 16 | Read data, valid the cycle after the request |
| done | output | 1 | One-cycle completion strobe |
| ea | output | 15 | Effective address |
| modifier | output | 7 | Modifier field of the accepted instruction |

## Verification
The bench builds the block with its default parameters: a 16-bit word, a 15-bit address, an 8-bit displacement and index words based at address 0. At these sizes every displacement value can be swept under all four index selectors. The sweep also varies the index words, including values with bit 15 set and values that force wrap-around. Two-word instructions are covered for every selector, with and without indirection, over a range of addresses that includes all-ones. The memory is modelled by an arithmetic function of the address, so each pointer word is known to the bench without storing an array.

// File: rtl/eag_pkg.sv
package eag_pkg;
    localparam int WORD_W  = 16;
    localparam int ADDR_W  = 15;
    localparam int OPC_W   = 5;
    localparam int TAG_W   = 2;
    localparam int FMT_BIT = WORD_W - OPC_W - 1;
    localparam int DISP_W  = FMT_BIT - TAG_W;
    localparam int MOD_W   = DISP_W - 1;
    localparam int XR_BASE = 0;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XR_REQ,
        ST_XR_WAIT,
        ST_IND_REQ,
        ST_IND_WAIT,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic              long_fmt;
        logic [TAG_W-1:0]  tag;
        logic              indirect;
        logic [MOD_W-1:0]  modifier;
        logic [DISP_W-1:0] disp;
    } instr_fields_t;

    function automatic addr_t sext_disp(input logic [DISP_W-1:0] d);
        return {{(ADDR_W-DISP_W){d[DISP_W-1]}}, d};
    endfunction

    function automatic addr_t wrap_add(input addr_t a, input addr_t b);
        return a + b;
    endfunction
endpackage

// File: rtl/eag_decode.sv
module eag_decode
    import eag_pkg::*;
(
    input  word_t         w0,
    output instr_fields_t fld
);
    logic opcode_unused;

    assign opcode_unused = ^w0[WORD_W-1 -: OPC_W];
    assign fld.long_fmt  = w0[FMT_BIT];
    assign fld.tag       = w0[FMT_BIT-1 -: TAG_W];
    assign fld.disp      = w0[DISP_W-1:0];
    // In the one-word form the top displacement bit is a sign, never an indirect flag
    assign fld.indirect  = w0[FMT_BIT] & w0[DISP_W-1];
    assign fld.modifier  = w0[MOD_W-1:0];
endmodule

// File: rtl/eag_seq.sv
module eag_seq
    import eag_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic need_xr,
    input  logic need_ind,
    output logic load,
    output logic xr_req,
    output logic xr_cap,
    output logic ind_req,
    output logic ind_cap,
    output logic busy,
    output logic done
);
    seq_state_e st, nxt;
    logic       ind_q;

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (start) begin
                    if (need_xr)       nxt = ST_XR_REQ;
                    else if (need_ind) nxt = ST_IND_REQ;
                    else               nxt = ST_FIN;
                end
            end
            ST_XR_REQ:   nxt = ST_XR_WAIT;
            ST_XR_WAIT:  nxt = ind_q ? ST_IND_REQ : ST_FIN;
            ST_IND_REQ:  nxt = ST_IND_WAIT;
            ST_IND_WAIT: nxt = ST_FIN;
            ST_FIN:      nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            ind_q <= 1'b0;
        end else begin
            st <= nxt;
            if (load) ind_q <= need_ind;
        end
    end

    assign load    = (st == ST_IDLE) && start;
    assign xr_req  = (st == ST_XR_REQ);
    assign xr_cap  = (st == ST_XR_WAIT);
    assign ind_req = (st == ST_IND_REQ);
    assign ind_cap = (st == ST_IND_WAIT);
    assign busy    = (st != ST_IDLE);
    assign done    = (st == ST_FIN);

    // R7: completion strobe lasts a single cycle
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: a read request is never followed directly by another
    assert_reads_spaced_R7: assert property (@(posedge clk) disable iff (rst)
        (xr_req || ind_req) |=> !(xr_req || ind_req));

    // R2: no index and no indirection means completion in the next cycle
    assert_direct_fast_R2: assert property (@(posedge clk) disable iff (rst)
        (load && !need_xr && !need_ind) |=> done);
endmodule

// File: rtl/eag_datapath.sv
module eag_datapath
    import eag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              xr_req,
    input  logic              xr_cap,
    input  logic              ind_req,
    input  logic              ind_cap,
    input  logic              busy,
    input  logic              long_fmt,
    input  logic [TAG_W-1:0]  tag,
    input  logic [DISP_W-1:0] disp,
    input  logic [MOD_W-1:0]  mod_in,
    input  word_t             w1,
    input  addr_t             iar,
    input  word_t             rdata,
    output logic              rd_en,
    output addr_t             rd_addr,
    output addr_t             ea,
    output logic [MOD_W-1:0]  mod_out
);
    addr_t            acc;
    addr_t            offset;
    addr_t            origin;
    logic [TAG_W-1:0] tag_q;
    logic [MOD_W-1:0] mod_q;
    logic             msb_unused;

    assign msb_unused = w1[WORD_W-1] ^ rdata[WORD_W-1];

    always_comb begin
        offset = long_fmt ? w1[ADDR_W-1:0] : sext_disp(disp);
        origin = (!long_fmt && (tag == '0)) ? iar : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            tag_q <= '0;
            mod_q <= '0;
        end else if (load) begin
            acc   <= wrap_add(offset, origin);
            tag_q <= tag;
            mod_q <= mod_in;
        end else if (xr_cap) begin
            acc <= wrap_add(acc, rdata[ADDR_W-1:0]);
        end else if (ind_cap) begin
            acc <= rdata[ADDR_W-1:0];
        end
    end

    assign rd_en   = xr_req | ind_req;
    assign rd_addr = xr_req ? (addr_t'(XR_BASE) + addr_t'(tag_q)) : acc;
    assign ea      = acc;
    assign mod_out = mod_q;

    // R8: result register moves only when a new instruction is accepted
    assert_ea_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !load) |=> $stable(acc));

    // R3: index fetches target one of the three index words
    assert_xr_addr_R3: assert property (@(posedge clk) disable iff (rst)
        xr_req |-> (rd_addr >= addr_t'(XR_BASE + 1) && rd_addr <= addr_t'(XR_BASE + 3)));
endmodule

// File: rtl/eag_top.sv
module eag_top
    import eag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] instr_w0,
    input  logic [WORD_W-1:0] instr_w1,
    input  logic [ADDR_W-1:0] next_iar,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              done,
    output logic [ADDR_W-1:0] ea,
    output logic [MOD_W-1:0]  modifier
);
    instr_fields_t fld;
    logic load, xr_req, xr_cap, ind_req, ind_cap, busy;

    eag_decode u_decode (
        .w0  (instr_w0),
        .fld (fld)
    );

    eag_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .need_xr  (fld.tag != '0),
        .need_ind (fld.indirect),
        .load     (load),
        .xr_req   (xr_req),
        .xr_cap   (xr_cap),
        .ind_req  (ind_req),
        .ind_cap  (ind_cap),
        .busy     (busy),
        .done     (done)
    );

    eag_datapath u_dp (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .xr_req   (xr_req),
        .xr_cap   (xr_cap),
        .ind_req  (ind_req),
        .ind_cap  (ind_cap),
        .busy     (busy),
        .long_fmt (fld.long_fmt),
        .tag      (fld.tag),
        .disp     (fld.disp),
        .mod_in   (fld.modifier),
        .w1       (instr_w1),
        .iar      (next_iar),
        .rdata    (mem_rd_data),
        .rd_en    (mem_rd_en),
        .rd_addr  (mem_rd_addr),
        .ea       (ea),
        .mod_out  (modifier)
    );

    // R9: a start during a computation leaves the latched instruction alone
    assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> $stable(modifier));

    // R11: nothing is read while idle
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_rd_en);
endmodule

// File: tb/tb_eag_top.sv
`timescale 1ns/1ps
module tb_eag_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] w0 = '0;
    logic [15:0] w1 = '0;
    logic [14:0] iar = '0;
    logic        mem_rd_en;
    logic [14:0] mem_rd_addr;
    logic [15:0] mem_rd_data = '0;
    logic        done;
    logic [14:0] ea;
    logic [6:0]  modifier;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [15:0] xr_val [4];

    eag_top dut (
        .clk(clk), .rst(rst), .start(start),
        .instr_w0(w0), .instr_w1(w1), .next_iar(iar),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .done(done), .ea(ea), .modifier(modifier)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] memword(input logic [14:0] a);
        if (a >= 15'd1 && a <= 15'd3) return xr_val[a[1:0]];
        return ({1'b0, a} * 16'h9E37) ^ 16'hA5C3;
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_rd_data <= memword(mem_rd_addr);

    task automatic report_summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: act cycles %0d exp completion earlier", cyc);
            report_summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act 0x%0h exp 0x%0h", what, act, exp);
        end
    endtask

    function automatic logic [14:0] exp_ea(input logic [15:0] i0, input logic [15:0] i1,
                                           input logic [14:0] pc);
        logic [14:0] off, base, a;
        logic [15:0] ptr;
        off  = i0[10] ? i1[14:0] : {{7{i0[7]}}, i0[7:0]};
        if (i0[9:8] == 2'b00) base = i0[10] ? 15'd0 : pc;
        else base = memword({13'd0, i0[9:8]}) & 16'h7FFF;
        a = off + base;
        if (i0[10] && i0[7]) begin
            ptr = memword(a);
            a = ptr[14:0];
        end
        return a;
    endfunction

    task automatic do_case(input logic [15:0] i0, input logic [15:0] i1,
                           input logic [14:0] pc, input string req);
        int          lat;
        int          nreads;
        logic [14:0] e_exp, ea_seen;
        logic [6:0]  m_seen;
        e_exp  = exp_ea(i0, i1, pc);
        nreads = int'(i0[9:8] != 2'b00) + int'(i0[10] & i0[7]);
        w0 = i0; w1 = i1; iar = pc; start = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            lat++;
        end while (!done && lat < 20);
        chk(lat == 1 + 2*nreads, "R7 latency", lat, 1 + 2*nreads);
        chk(ea == e_exp, req, ea, e_exp);
        chk(modifier == i0[6:0], "R10 modifier", modifier, i0[6:0]);
        ea_seen = ea;
        m_seen  = modifier;
        w0 = ~i0; w1 = ~i1; iar = ~pc;
        @(negedge clk);
        chk(!done, "R7 single pulse", done, 0);
        @(negedge clk);
        chk(ea == ea_seen && modifier == m_seen, "R8 hold", {ea, modifier}, {ea_seen, m_seen});
    endtask

    initial begin
        xr_val[0] = 16'h0000;
        xr_val[1] = 16'h0100;
        xr_val[2] = 16'h8123;
        xr_val[3] = 16'h7FFF;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!done && !mem_rd_en && ea == 15'd0 && modifier == 7'd0, "R11 during reset",
            {done, mem_rd_en, ea, modifier}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !mem_rd_en && ea == 15'd0 && modifier == 7'd0, "R11 after reset",
            {done, mem_rd_en, ea, modifier}, 0);

        // R2/R3: full displacement sweep for every selector, one-word form
        for (int t = 0; t < 4; t++) begin
            for (int d = 0; d < 256; d++) begin
                xr_val[1] = 16'((d * 331) ^ 16'h8000);
                xr_val[2] = 16'((d * 1237) + 16'h7F00);
                xr_val[3] = 16'((d * 77) ^ 16'hFFFF);
                do_case({5'(d), 1'b0, 2'(t), 8'(d)}, 16'(d * 7), 15'((d * 97) + 15'h7F80),
                        (t == 0) ? "R2 relative" : "R3 indexed short");
            end
        end

        // R4/R5: two-word form, every selector, with and without indirection
        for (int t = 0; t < 4; t++) begin
            for (int ind = 0; ind < 2; ind++) begin
                for (int k = 0; k < 16; k++) begin
                    xr_val[1] = 16'(k * 4099);
                    xr_val[2] = 16'hF000 ^ 16'(k);
                    xr_val[3] = 16'h7FFF - 16'(k);
                    do_case({5'(k), 1'b1, 2'(t), 1'(ind), 7'(k * 9 + t)},
                            16'(k * 16'h1111), 15'(k * 3),
                            (ind == 0) ? "R4 long direct" : "R5 long indirect");
                end
            end
        end

        // R6: explicit wrap cases against literal values
        do_case(16'b00000_0_00_10000000, 16'h0, 15'd5, "R6 wrap short");
        chk(ea == 15'h7F85, "R6 wrap literal short", ea, 15'h7F85);
        do_case(16'b00000_1_00_0_0000000, 16'hFFFF, 15'd0, "R6 msb dropped");
        chk(ea == 15'h7FFF, "R6 msb literal", ea, 15'h7FFF);
        xr_val[1] = 16'hFFFF;
        do_case(16'b00000_1_01_0_0000000, 16'h0002, 15'd0, "R6 index wrap");
        chk(ea == 15'h0001, "R6 index wrap literal", ea, 15'h0001);

        // R1: one-word form with negative displacement is not indirect (latency 1)
        do_case(16'b11111_0_00_11111111, 16'hFFFF, 15'd100, "R1 short sign not indirect");
        chk(ea == 15'd99, "R1 literal", ea, 15'd99);

        // R9: start while busy is ignored
        begin
            int          lat;
            int          pulses;
            logic [15:0] a0;
            logic [15:0] a1;
            logic [14:0] e_exp;
            xr_val[2] = 16'h0040;
            a0 = 16'b00001_1_10_1_0101010;
            a1 = 16'h0123;
            e_exp = exp_ea(a0, a1, 15'd0);
            w0 = a0; w1 = a1; iar = 15'd0; start = 1'b1;
            @(negedge clk);
            lat = 1;
            w0 = 16'b00000_0_00_00000011; w1 = 16'h0; iar = 15'd10; start = 1'b1;
            @(negedge clk);
            lat++;
            start = 1'b0;
            while (!done && lat < 20) begin
                @(negedge clk);
                lat++;
            end
            chk(lat == 5, "R9 latency unchanged", lat, 5);
            chk(ea == e_exp, "R9 result unchanged", ea, e_exp);
            chk(modifier == 7'b0101010, "R9 modifier unchanged", modifier, 7'b0101010);
            pulses = 0;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                if (done) pulses++;
            end
            chk(pulses == 0, "R9 no extra done", pulses, 0);
        end

        report_summary();
        $finish;
    end
endmodule